// File: doc/BRIEF.md
# Serially Configured Multiplexer-Tree Lookup Table

This block is a K-input logic cell. Its function is held as a truth table of 2^K volatile storage bits. The logic inputs steer a binary tree of 2-to-1 multiplexers over those bits. The stage nearest the leaves is driven by the last input and the final stage by the first input. The tree therefore splits the function into the cofactors of the first input, which is Shannon expansion.

The stored bits lose their contents at power-up, so they are filled through a one-bit serial chain. Each clock with the shift enable high moves the chain by one place. The bit that leaves the far end appears on a chain output, so several cells can be daisy-chained.

A ready flag rises after exactly 2^K shifts since reset. Until then the function output is held at 0. Once ready, the output is a purely combinational function of the inputs and the loaded table.

Top module: `shannon_lut`

## Requirements
- R1: While `rst` is high at a rising clock edge, the storage chain is cleared and `cfg_done` goes low. After the edge `cfg_dout` and `f_out` read 0.
- R2: While `cfg_done` is low, `f_out` is 0 for every input value and every partial load.
- R3: `cfg_done` rises at the edge of the 2^K-th enabled shift counted since reset, and is still low after 2^K-1 shifts.
- R4: A clock edge with `cfg_en` low changes neither the chain nor the shift count, so `cfg_dout` holds and readiness is not advanced.
- R5: Bits are shifted in MSB first. The first bit of a 2^K-bit stream lands in cell 2^K-1 and the last bit lands in cell 0. Cell i holds f for the input value i, where `lut_in[K-1]` (the first input) is the most significant bit.
- R6: Once `cfg_done` is high, `f_out` equals the cell addressed by `lut_in`, with no clock delay.
- R7: `cfg_dout` always shows cell 2^K-1, which is the next bit to leave the chain. Shifting a new stream into a loaded cell therefore reproduces the old stream on `cfg_dout` in the order it was loaded.
- R8: `cfg_done` stays high until the next reset. Further shifts reload the table, and `f_out` follows the new contents.
- R9: Loading 1,0,0,1 for the combinations 00,01,10,11 of the first two inputs, repeated over the other inputs, gives f = x1'x2' + x1x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain and the counter |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration bit in |
| cfg_dout | output | 1 | Serial bit out (cell 2^K-1), for daisy-chaining |
| cfg_done | output | 1 | High once 2^K shifts have occurred since reset |
| lut_in | input | K | Logic inputs; bit K-1 is the first input x1 |
| f_out | output | 1 | Table output, gated by cfg_done |

## Verification
The bench goes after bit order. A design that reversed the stream, or reversed the order of the select bits in the tree, would read the wrong cell for asymmetric tables while still passing symmetric ones. For that reason, asymmetric patterns are loaded and every input value is read back.

Readiness is probed at exactly 2^K-1 and 2^K shifts. An off-by-one counter would raise the flag one shift early or late and expose a half-loaded table.

Idle cycles are inserted in the middle of a load. A design that shifted without the enable would corrupt both the table and the count.

Finally, a second table is shifted in after the first load. This checks that the old stream emerges intact on the chain output and that the flag does not drop.

// File: rtl/shannon_lut_pkg.sv
package shannon_lut_pkg;
  // number of shifts needed for a full load of a K-input table
  function automatic int unsigned cells_of(input int unsigned k);
    return 32'd1 << k;
  endfunction
endpackage

// File: rtl/slut_chain.sv
// Volatile storage cells arranged as a serial shift chain, MSB first.
module slut_chain #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [N-1:0] cells,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cells <= '0;
    end else if (shift_en) begin
      cells <= {cells[N-2:0], din};
    end
  end

  assign dout = cells[N-1];
endmodule

// File: rtl/slut_loadctl.sv
// Counts enabled shifts after reset and raises a sticky ready flag.
module slut_loadctl #(
  parameter int unsigned N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  output logic ready
);
  localparam int unsigned CW = $clog2(N) + 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (shift_en && !ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/slut_tree.sv
// Binary 2-to-1 multiplexer tree: level t selects with sel[t-1];
// the root stage is steered by sel[K-1] (first input, Shannon split).
module slut_tree #(
  parameter int unsigned K = 4,
  localparam int unsigned N = 1 << K
) (
  input  logic [N-1:0] leaves,
  input  logic [K-1:0] sel,
  output logic         root
);
  for (genvar t = 0; t <= K; t++) begin : g_lv
    localparam int unsigned W = 1 << (K - t);
    logic [W-1:0] v;
    if (t == 0) begin : g_leaf
      assign v = leaves;
    end else begin : g_mux
      for (genvar m = 0; m < W; m++) begin : g_node
        assign v[m] = sel[t-1] ? g_lv[t-1].v[2*m+1] : g_lv[t-1].v[2*m];
      end
    end
  end

  assign root = g_lv[K].v[0];
endmodule

// File: rtl/shannon_lut.sv
module shannon_lut #(
  parameter int unsigned K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic         cfg_dout,
  output logic         cfg_done,
  input  logic [K-1:0] lut_in,
  output logic         f_out
);
  import shannon_lut_pkg::*;
  localparam int unsigned N = cells_of(K);

  logic [N-1:0] cells;
  logic         tree_out;

  slut_chain #(.N(N)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_en), .din(cfg_din),
    .cells(cells), .dout(cfg_dout)
  );

  slut_loadctl #(.N(N)) u_ctl (
    .clk(clk), .rst(rst), .shift_en(cfg_en), .ready(cfg_done)
  );

  slut_tree #(.K(K)) u_tree (
    .leaves(cells), .sel(lut_in), .root(tree_out)
  );

  assign f_out = cfg_done & tree_out;
endmodule

// File: rtl/shannon_lut_chk.sv
module shannon_lut_chk #(
  parameter int unsigned K = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_en,
  input logic         cfg_dout,
  input logic         cfg_done,
  input logic [K-1:0] lut_in,
  input logic         f_out
);
  // R1
  rst_clears_chk: assert property (@(posedge clk) rst |=> (!cfg_done && !cfg_dout));
  // R2
  gated_out_chk: assert property (@(posedge clk) disable iff (rst) !cfg_done |-> !f_out);
  // R3
  done_needs_shift_chk: assert property (@(posedge clk) disable iff (rst) $rose(cfg_done) |-> $past(cfg_en));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !cfg_en |=> ($stable(cfg_dout) && $stable(cfg_done)));
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst) cfg_done |=> cfg_done);
endmodule

bind shannon_lut shannon_lut_chk #(.K(K)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_dout(cfg_dout),
  .cfg_done(cfg_done), .lut_in(lut_in), .f_out(f_out)
);

// File: tb/sim_shannon_lut.sv
`timescale 1ns/1ps
module sim_shannon_lut;
  localparam int K = 4;
  localparam int N = 1 << K;
  localparam int NT = 5;
  // truth tables: bit i = f for input value i (x1 = lut_in[3] is MSB)
  localparam logic [N-1:0] TABLES [NT] = '{
    16'h8001, 16'h00FF, 16'h1234, 16'hC3A5, 16'hFFFE
  };

  logic clk = 0, rst = 1, cfg_en = 0, cfg_din = 0;
  logic [K-1:0] lut_in = '0;
  logic cfg_dout, cfg_done, f_out;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shannon_lut #(.K(K)) u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .cfg_done(cfg_done), .lut_in(lut_in), .f_out(f_out)
  );

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1; cfg_en = 0;
    @(posedge clk); #1;
    rst = 0;
  endtask

  task automatic shift_bit(logic b);
    cfg_en = 1; cfg_din = b;
    @(posedge clk); #1;
    cfg_en = 0;
  endtask

  task automatic load(logic [N-1:0] tt);
    for (int i = N - 1; i >= 0; i--) shift_bit(tt[i]);
  endtask

  task automatic read_all(string req, logic [N-1:0] tt);
    for (int a = 0; a < N; a++) begin
      lut_in = K'(a); #1;
      chk(req, f_out, tt[a]);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 done", cfg_done, 1'b0);
    chk("R1 dout", cfg_dout, 1'b0);
    chk("R1 f", f_out, 1'b0);

    // vector table walk: R5/R6 addressing and bit order
    for (int t = 0; t < NT; t++) begin
      do_reset();
      load(TABLES[t]);
      chk("R3 done after full load", cfg_done, 1'b1);
      read_all("R5 R6 table read", TABLES[t]);
    end

    // R3 boundary, R2 gating and R4 idle cycles mid-load
    do_reset();
    for (int i = N - 1; i >= 1; i--) begin
      shift_bit(1'b1);
      if (i == 8) begin
        repeat (3) @(posedge clk);
        #1;
      end
    end
    chk("R3 not done at N-1", cfg_done, 1'b0);
    for (int a = 0; a < N; a += 5) begin
      lut_in = K'(a); #1;
      chk("R2 gated while loading", f_out, 1'b0);
    end
    repeat (4) @(posedge clk);
    #1;
    chk("R4 idle no advance", cfg_done, 1'b0);
    shift_bit(1'b1);
    chk("R3 done at N", cfg_done, 1'b1);
    read_all("R4 idle kept chain", 16'hFFFF);

    // R7 daisy chain and R8 reload
    do_reset();
    load(16'h1234);
    for (int i = N - 1; i >= 0; i--) begin
      chk("R7 chain out", cfg_dout, 1'b1 & 16'h1234 >> i);
      shift_bit(16'hC3A5 >> i);
      chk("R8 done sticky", cfg_done, 1'b1);
    end
    read_all("R8 reloaded table", 16'hC3A5);

    // R9 XNOR of x1,x2 (x3,x4 don't care): cells 0-3 and 12-15 set
    do_reset();
    load(16'hF00F);
    for (int a = 0; a < N; a++) begin
      lut_in = K'(a); #1;
      chk("R9 xnor", f_out, ~(lut_in[3] ^ lut_in[2]));
    end

    // R1 reset after load clears everything
    rst = 1; @(posedge clk); #1;
    chk("R1 done cleared", cfg_done, 1'b0);
    chk("R1 f cleared", f_out, 1'b0);
    rst = 0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule